// File: doc/BRIEF.md
# Paged Address Translator for an 8-bit CPU

This block gives a CPU with a 16-bit address bus access to a much larger external memory by bank switching. The CPU address space is split into equal areas. The top address bits pick one area, and a small table supplies a 16-bit bank number for that area. The bank number replaces those top bits, sits directly above the untouched low address bits, and forms a wide physical address for the memory controller. The same bank number also goes out on its own bus for external address decoding. Both outputs are combinational from the CPU address.

The table is loaded and read through CPU I/O ports, so it takes no space in the memory map. Each entry takes two adjacent byte ports. The even port holds the upper byte and the odd port holds the lower byte. Every entry can be read back through the port it was written through. After reset, each entry holds its own index, so the CPU sees one contiguous 64KB space until software changes the mapping.

The number of areas is a parameter. The default build has 4 areas of 16KB. A build with 16 areas of 4KB is also supported.

Top module: `pgmap_top`

## Requirements
- R1: The top `PAGE_BITS` bits of `cpu_addr` select the table entry. The default is bits [15:14], giving 4 areas of 16KB each.
- R2: `phys_addr` is the selected 16-bit entry placed directly above the low `16-PAGE_BITS` CPU address bits, with zeros above it up to `PHYS_W` (default 32) bits.
- R3: After reset, entry i holds the value i, so `phys_addr` equals `cpu_addr` zero-extended.
- R4: A port is identified by offset = `io_addr - IO_BASE`. Its entry index is offset>>1. Offset bit 0 = 0 selects entry bits [15:8], and 1 selects bits [7:0]. A write in range updates only that byte at the clock edge. Translation and readback use the new value from the next cycle on.
- R5: When `io_rd` is high and `io_addr` is in range, `io_rvalid` is high in that same cycle and `io_rdata` carries the addressed byte as stored before any write in that cycle.
- R6: An `io_addr` below `IO_BASE` or at or above `IO_BASE + 2*2^PAGE_BITS` is not claimed. It raises no `io_rvalid`, and a write to it changes no entry. `io_rdata` is zero whenever `io_rvalid` is low.
- R7: `ext_bank` carries the 16-bit entry of the area currently addressed by `cpu_addr`, combinationally.
- R8: With `PAGE_BITS` = 4 the block maps 16 areas of 4KB selected by bits [15:12] and uses 32 ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to the identity mapping |
| io_addr | input | IO_AW | I/O port address |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | Read-back byte, zero when not claimed |
| io_rvalid | output | 1 | High when a read hits the port range |
| cpu_addr | input | CPU_AW | CPU memory address |
| phys_addr | output | PHYS_W | Translated physical address |
| ext_bank | output | 16 | Bank number of the addressed area |

## Verification
A port write, a readback of the same port and a translation through the same entry can all fall in one cycle. The bench forces this case directly: it writes the lower byte of an entry while reading that port with the CPU address inside that area. In that cycle the read and the translation must show the old byte, and from the next cycle both must show the new one. Random traffic that mixes writes, reads and addresses just outside the range repeats this collision many times, and a behavioural model is compared against every output on every cycle.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

    localparam int ENTRY_W = 16;
    localparam int BYTE_W  = 8;

    typedef logic [ENTRY_W-1:0] entry_t;
    typedef logic [BYTE_W-1:0]  byte_t;

    // Even port offset addresses the upper byte, odd the lower one.
    typedef enum logic {
        HALF_HI = 1'b0,
        HALF_LO = 1'b1
    } half_e;

    function automatic entry_t merge_half(entry_t cur, byte_t val, half_e h);
        entry_t r;
        r = cur;
        if (h == HALF_HI) r[15:8] = val;
        else              r[7:0]  = val;
        return r;
    endfunction

    function automatic byte_t pick_half(entry_t cur, half_e h);
        return (h == HALF_HI) ? cur[15:8] : cur[7:0];
    endfunction

endpackage

// File: rtl/pgmap_port_dec.sv
module pgmap_port_dec
    import pgmap_pkg::*;
#(
    parameter int IO_AW     = 8,
    parameter int IO_BASE   = 'h40,
    parameter int PAGE_BITS = 2
) (
    input  logic [IO_AW-1:0]     io_addr,
    output logic                 hit,
    output logic [PAGE_BITS-1:0] idx,
    output half_e                half
);
    localparam int NPORTS = 2 * (1 << PAGE_BITS);

    logic [IO_AW-1:0] offset;

    always_comb begin
        offset = io_addr - IO_AW'(IO_BASE);
        hit    = (io_addr >= IO_AW'(IO_BASE))
              && ({1'b0, offset} < (IO_AW+1)'(NPORTS));
        idx    = offset[PAGE_BITS:1];
        half   = half_e'(offset[0]);
    end

endmodule

// File: rtl/pgmap_table.sv
module pgmap_table
    import pgmap_pkg::*;
#(
    parameter int PAGE_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PAGE_BITS-1:0] wr_idx,
    input  half_e                wr_half,
    input  byte_t                wr_byte,
    input  logic [PAGE_BITS-1:0] rd_idx,
    input  half_e                rd_half,
    output byte_t                rd_byte,
    input  logic [PAGE_BITS-1:0] xl_idx,
    output entry_t               xl_entry
);
    localparam int NPAGES = 1 << PAGE_BITS;

    typedef struct packed {
        logic [NPAGES-1:0][ENTRY_W-1:0] ent;
    } tbl_t;

    function automatic tbl_t identity_map();
        tbl_t t;
        for (int i = 0; i < NPAGES; i++) t.ent[i] = ENTRY_W'(i);
        return t;
    endfunction

    localparam tbl_t RESET_TBL = identity_map();

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_idx] = merge_half(st_q.ent[wr_idx], wr_byte, wr_half);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_TBL;
        else        st_q <= st_d;
    end

    assign rd_byte  = pick_half(st_q.ent[rd_idx], rd_half);
    assign xl_entry = st_q.ent[xl_idx];

endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate
    import pgmap_pkg::*;
#(
    parameter int CPU_AW    = 16,
    parameter int PAGE_BITS = 2,
    parameter int PHYS_W    = 32
) (
    input  logic [CPU_AW-1:0]    cpu_addr,
    output logic [PAGE_BITS-1:0] page_idx,
    input  entry_t               entry,
    output logic [PHYS_W-1:0]    phys_addr
);
    localparam int OFF_W = CPU_AW - PAGE_BITS;
    localparam int PAD_W = PHYS_W - ENTRY_W - OFF_W;

    assign page_idx = cpu_addr[CPU_AW-1 -: PAGE_BITS];

    generate
        if (PAD_W > 0) begin : g_pad
            assign phys_addr = {{PAD_W{1'b0}}, entry, cpu_addr[OFF_W-1:0]};
        end else begin : g_exact
            assign phys_addr = {entry, cpu_addr[OFF_W-1:0]};
        end
    endgenerate

endmodule

// File: rtl/pgmap_top.sv
module pgmap_top
    import pgmap_pkg::*;
#(
    parameter int CPU_AW    = 16,
    parameter int PAGE_BITS = 2,
    parameter int IO_AW     = 8,
    parameter int IO_BASE   = 'h40,
    parameter int PHYS_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_rvalid,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [15:0]       ext_bank
);
    logic                 port_hit;
    logic [PAGE_BITS-1:0] port_idx;
    half_e                port_half;
    logic [PAGE_BITS-1:0] page_idx;
    byte_t                rd_byte;
    entry_t               cur_entry;

    pgmap_port_dec #(
        .IO_AW    (IO_AW),
        .IO_BASE  (IO_BASE),
        .PAGE_BITS(PAGE_BITS)
    ) dec_i (
        .io_addr(io_addr),
        .hit    (port_hit),
        .idx    (port_idx),
        .half   (port_half)
    );

    pgmap_table #(
        .PAGE_BITS(PAGE_BITS)
    ) tbl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (io_wr & port_hit),
        .wr_idx  (port_idx),
        .wr_half (port_half),
        .wr_byte (io_wdata),
        .rd_idx  (port_idx),
        .rd_half (port_half),
        .rd_byte (rd_byte),
        .xl_idx  (page_idx),
        .xl_entry(cur_entry)
    );

    pgmap_xlate #(
        .CPU_AW   (CPU_AW),
        .PAGE_BITS(PAGE_BITS),
        .PHYS_W   (PHYS_W)
    ) xl_i (
        .cpu_addr (cpu_addr),
        .page_idx (page_idx),
        .entry    (cur_entry),
        .phys_addr(phys_addr)
    );

    assign io_rvalid = io_rd & port_hit;
    assign io_rdata  = io_rvalid ? rd_byte : '0;
    assign ext_bank  = cur_entry;

endmodule

// File: rtl/pgmap_chk.sv
module pgmap_chk #(
    parameter int CPU_AW    = 16,
    parameter int PAGE_BITS = 2,
    parameter int IO_AW     = 8,
    parameter int IO_BASE   = 'h40,
    parameter int PHYS_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IO_AW-1:0]  io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              io_rvalid,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [PHYS_W-1:0] phys_addr,
    input logic [15:0]       ext_bank
);
    localparam int NPORTS = 2 * (1 << PAGE_BITS);
    localparam int OFF_W  = CPU_AW - PAGE_BITS;

    logic in_rng;
    logic touched_q;

    assign in_rng = ({1'b0, io_addr} >= (IO_AW+1)'(IO_BASE))
                 && ({1'b0, io_addr} <  (IO_AW+1)'(IO_BASE + NPORTS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 touched_q <= 1'b0;
        else if (io_wr && in_rng)   touched_q <= 1'b1;
    end

    AST_IDENTITY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !touched_q |-> ext_bank == 16'(cpu_addr[CPU_AW-1 -: PAGE_BITS])); // R3

    AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]); // R2

    AST_BANK_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr == PHYS_W'({ext_bank, cpu_addr[OFF_W-1:0]})); // R7

    AST_UNCLAIMED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !in_rng |-> !io_rvalid && io_rdata == 8'h00); // R6

    AST_CLAIMED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && in_rng) |-> io_rvalid); // R5

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && in_rng) |=>
            (!(io_rd && io_addr == $past(io_addr)) || io_rdata == $past(io_wdata))); // R4

    AST_TABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && in_rng) |=> (!$stable(cpu_addr) || $stable(ext_bank))); // R6

endmodule

bind pgmap_top pgmap_chk #(
    .CPU_AW   (CPU_AW),
    .PAGE_BITS(PAGE_BITS),
    .IO_AW    (IO_AW),
    .IO_BASE  (IO_BASE),
    .PHYS_W   (PHYS_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .io_rvalid(io_rvalid),
    .cpu_addr (cpu_addr),
    .phys_addr(phys_addr),
    .ext_bank (ext_bank)
);

// File: tb/pgmap_top_tb.sv
`timescale 1ns/1ps
module pgmap_top_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;
    logic rst_n = 1'b0;

    logic [7:0]  a_io_addr = '0, a_wdata = '0, a_rdata;
    logic        a_wr = 1'b0, a_rd = 1'b0, a_rvalid;
    logic [15:0] a_cpu = '0, a_bank;
    logic [31:0] a_phys;

    logic [7:0]  b_io_addr = '0, b_wdata = '0, b_rdata;
    logic        b_wr = 1'b0, b_rd = 1'b0, b_rvalid;
    logic [15:0] b_cpu = '0, b_bank;
    logic [31:0] b_phys;

    pgmap_top #(.PAGE_BITS(2), .IO_BASE('h40)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(a_io_addr), .io_wr(a_wr), .io_rd(a_rd),
        .io_wdata(a_wdata), .io_rdata(a_rdata), .io_rvalid(a_rvalid),
        .cpu_addr(a_cpu), .phys_addr(a_phys), .ext_bank(a_bank));

    pgmap_top #(.PAGE_BITS(4), .IO_BASE('h80)) dut16_i (
        .clk(clk), .rst_n(rst_n), .io_addr(b_io_addr), .io_wr(b_wr), .io_rd(b_rd),
        .io_wdata(b_wdata), .io_rdata(b_rdata), .io_rvalid(b_rvalid),
        .cpu_addr(b_cpu), .phys_addr(b_phys), .ext_bank(b_bank));

    int checks = 0, fails = 0;
    bit done = 0;
    int ma [4];
    int mb [16];
    int oa, ob;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: entries updated at the edge that samples a write.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (ma[i]) ma[i] = i;
            foreach (mb[i]) mb[i] = i;
        end else begin
            if (a_wr && a_io_addr >= 8'h40 && a_io_addr < 8'h48) begin
                oa = int'(a_io_addr) - 'h40;
                if (oa % 2 == 0) ma[oa/2] = (ma[oa/2] & 'hFF) | (int'(a_wdata) << 8);
                else             ma[oa/2] = (ma[oa/2] & 'hFF00) | int'(a_wdata);
            end
            if (b_wr && b_io_addr >= 8'h80 && b_io_addr < 8'hA0) begin
                ob = int'(b_io_addr) - 'h80;
                if (ob % 2 == 0) mb[ob/2] = (mb[ob/2] & 'hFF) | (int'(b_wdata) << 8);
                else             mb[ob/2] = (mb[ob/2] & 'hFF00) | int'(b_wdata);
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int ia, ib, pa, pb;
            ia = int'(a_cpu[15:14]);
            chk("R2", "phys_addr", 64'(a_phys), 64'((ma[ia] * 'h4000) + int'(a_cpu[13:0])));
            chk("R7", "ext_bank", 64'(a_bank), 64'(ma[ia]));
            if (a_rd && a_io_addr >= 8'h40 && a_io_addr < 8'h48) begin
                pa = int'(a_io_addr) - 'h40;
                chk("R5", "rvalid", 64'(a_rvalid), 64'd1);
                chk("R5", "rdata", 64'(a_rdata),
                    64'((pa % 2 == 0) ? (ma[pa/2] >> 8) : (ma[pa/2] & 'hFF)));
            end else begin
                chk("R6", "rvalid", 64'(a_rvalid), 64'd0);
                chk("R6", "rdata", 64'(a_rdata), 64'd0);
            end
            ib = int'(b_cpu[15:12]);
            chk("R8", "phys_addr16", 64'(b_phys), 64'((mb[ib] * 'h1000) + int'(b_cpu[11:0])));
            chk("R8", "ext_bank16", 64'(b_bank), 64'(mb[ib]));
            if (b_rd && b_io_addr >= 8'h80 && b_io_addr < 8'hA0) begin
                pb = int'(b_io_addr) - 'h80;
                chk("R8", "rvalid16", 64'(b_rvalid), 64'd1);
                chk("R8", "rdata16", 64'(b_rdata),
                    64'((pb % 2 == 0) ? (mb[pb/2] >> 8) : (mb[pb/2] & 'hFF)));
            end else begin
                chk("R8", "rvalid16", 64'(b_rvalid), 64'd0);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic a_write(logic [7:0] adr, logic [7:0] d);
        a_io_addr = adr; a_wdata = d; a_wr = 1'b1;
        step();
        a_wr = 1'b0;
    endtask

    task automatic b_write(logic [7:0] adr, logic [7:0] d);
        b_io_addr = adr; b_wdata = d; b_wr = 1'b1;
        step();
        b_wr = 1'b0;
    endtask

    task automatic a_read_chk(logic [7:0] adr, logic v, logic [7:0] d, string req);
        a_io_addr = adr; a_rd = 1'b1;
        @(negedge clk);
        chk(req, "read valid", 64'(a_rvalid), 64'(v));
        chk(req, "read data", 64'(a_rdata), 64'(d));
        step();
        a_rd = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        // Reset state seen during reset.
        a_cpu = 16'hC123;
        @(negedge clk);
        chk("R3", "bank in reset", 64'(a_bank), 64'd3);
        step();
        rst_n = 1'b1;
        step();

        // R3 / R1: identity mapping over every area.
        for (int i = 0; i < 4; i++) begin
            a_cpu = 16'(i * 'h4000 + 'h0ABC);
            @(negedge clk);
            chk("R3", "identity phys", 64'(a_phys), 64'(a_cpu));
            chk("R1", "area select", 64'(a_bank), 64'(i));
            step();
        end
        a_read_chk(8'h41, 1'b1, 8'h00, "R5");
        a_read_chk(8'h47, 1'b1, 8'h03, "R5");
        a_read_chk(8'h46, 1'b1, 8'h00, "R5");

        // R4: upper byte of entry 1 only.
        a_write(8'h42, 8'hAB);
        a_read_chk(8'h43, 1'b1, 8'h01, "R4");
        a_read_chk(8'h42, 1'b1, 8'hAB, "R4");
        a_cpu = 16'h4567;
        @(negedge clk);
        chk("R4", "phys after hi write", 64'(a_phys), 64'h2AC0_4567);
        chk("R7", "ext bank", 64'(a_bank), 64'hAB01);
        step();

        // Collision: write, read and translate through entry 1 in one cycle.
        a_io_addr = 8'h43; a_wdata = 8'h5C; a_wr = 1'b1; a_rd = 1'b1;
        @(negedge clk);
        chk("R5", "old byte on collision", 64'(a_rdata), 64'h01);
        chk("R4", "old bank on collision", 64'(a_bank), 64'hAB01);
        step();
        a_wr = 1'b0;
        @(negedge clk);
        chk("R4", "new byte next cycle", 64'(a_rdata), 64'h5C);
        chk("R4", "new bank next cycle", 64'(a_bank), 64'hAB5C);
        step();
        a_rd = 1'b0;

        // R6: just outside the range on both sides.
        a_write(8'h3F, 8'hEE);
        a_write(8'h48, 8'hEE);
        a_write(8'hFF, 8'hEE);
        a_read_chk(8'h3F, 1'b0, 8'h00, "R6");
        a_read_chk(8'h48, 1'b0, 8'h00, "R6");
        a_read_chk(8'h40, 1'b1, 8'h00, "R6");
        a_read_chk(8'h47, 1'b1, 8'h03, "R6");

        // R8: 16 areas of 4KB.
        for (int i = 0; i < 16; i++) begin
            b_cpu = 16'(i * 'h1000 + 'h0123);
            @(negedge clk);
            chk("R8", "identity16", 64'(b_phys), 64'(b_cpu));
            step();
        end
        b_write(8'h8A, 8'h12);
        b_write(8'h8B, 8'h34);
        b_cpu = 16'h5ABC;
        @(negedge clk);
        chk("R8", "phys16 remapped", 64'(b_phys), 64'h0123_4ABC);
        step();
        b_io_addr = 8'h9F; b_rd = 1'b1;
        @(negedge clk);
        chk("R8", "last port valid", 64'(b_rvalid), 64'd1);
        chk("R8", "last port data", 64'(b_rdata), 64'h0F);
        step();
        b_io_addr = 8'hA0;
        @(negedge clk);
        chk("R8", "past last port", 64'(b_rvalid), 64'd0);
        step();
        b_rd = 1'b0;

        // Mixed random traffic, checked every cycle by the model.
        for (int n = 0; n < 4000; n++) begin
            a_io_addr = 8'(8'h3E + $urandom_range(0, 11));
            a_wr      = ($urandom_range(0, 2) == 0);
            a_rd      = $urandom_range(0, 1) == 1;
            a_wdata   = 8'($urandom);
            a_cpu     = 16'($urandom);
            b_io_addr = 8'(8'h7E + $urandom_range(0, 35));
            b_wr      = ($urandom_range(0, 2) == 0);
            b_rd      = $urandom_range(0, 1) == 1;
            b_wdata   = 8'($urandom);
            b_cpu     = 16'($urandom);
            step();
        end
        a_wr = 1'b0; a_rd = 1'b0; b_wr = 1'b0; b_rd = 1'b0;

        // R3: a second reset restores identity.
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        a_cpu = 16'h8001;
        b_cpu = 16'hE00F;
        @(negedge clk);
        chk("R3", "identity after rerun", 64'(a_phys), 64'h8001);
        chk("R3", "identity16 after rerun", 64'(b_phys), 64'hE00F);
        step();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule